// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block is the add/subtract slice of an integer execution stage. Each issued operation takes two 32-bit operands and produces a 32-bit result together with the next negative, zero, overflow and carry flags. The operation is always addition or subtraction. Three modifier flags select the variant. Extend folds the carry flag left by the previous operation into the sum, or into the difference as a borrow. Tagged treats the two low bits of each operand as a type tag. Trap-enable turns a tag or overflow fault on a tagged operation into a trap request.

The tag check runs alongside the adder in the same cycle as the arithmetic. A separate set-cc flag chooses whether the flags are committed. When a trapping tagged operation faults, the unit raises a trap and holds back both the destination write and the flag write, so the faulting operation leaves no architectural trace. All outputs are registered and appear on the cycle after issue. The block has no state machine. Its only states are reset and running, and every issued operation completes in one pass through a single pipeline register.

Top module: `tag_alu`

## Requirements
- R1: After reset, and on any cycle that follows a cycle with `issue_i` low, `res_we_o`, `cc_we_o` and `tag_trap_o` are 0. Every issued operation drives its outputs on the clock edge that samples it, so they are visible one cycle after issue.
- R2: An add (`sub_i`=0) returns `opa_i + opb_i + cin` modulo 2^32. `flag_c_o` is the unsigned carry out of bit 31.
- R3: A subtract (`sub_i`=1) returns `opa_i - opb_i - cin` modulo 2^32. `flag_c_o` is 1 exactly when the unsigned `opa_i` is less than `opb_i + cin`, which is a borrow.
- R4: For an untagged operation, `cin` is `carry_i` when `extend_i`=1 and 0 otherwise.
- R5: `flag_n_o` equals result bit 31, and `flag_z_o` is 1 exactly when all 32 result bits are zero.
- R6: For an untagged operation, `flag_v_o` is 1 exactly when the true signed result, taken with its carry/borrow-in, falls outside the signed 32-bit range.
- R7: For a tagged operation (`tagged_i`=1), `flag_v_o` is 1 when bits 1:0 of either operand are nonzero or when a signed overflow occurs.
- R8: A tagged operation uses a carry-in of 0 whatever the values of `extend_i` and `carry_i`.
- R9: An operation that is tagged, has `trap_en_i`=1 and meets the R7 overflow condition sets `tag_trap_o`=1 and keeps both `res_we_o` and `cc_we_o` at 0.
- R10: `trap_en_i` has no effect when `tagged_i`=0. Such an operation never traps, and its result and flags follow R2 to R6.
- R11: A non-trapping issued operation sets `res_we_o`=1, and sets `cc_we_o` equal to `set_cc_i`. With `set_cc_i`=0 the result is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is presented this cycle |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| extend_i | input | 1 | Include the carry/borrow flag |
| tagged_i | input | 1 | Tagged form |
| trap_en_i | input | 1 | Trap on a tag or overflow fault (tagged only) |
| set_cc_i | input | 1 | Commit flags |
| carry_i | input | 1 | Current carry flag |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Result |
| res_we_o | output | 1 | Destination write enable |
| flag_n_o | output | 1 | Next negative flag |
| flag_z_o | output | 1 | Next zero flag |
| flag_v_o | output | 1 | Next overflow flag |
| flag_c_o | output | 1 | Next carry/borrow flag |
| cc_we_o | output | 1 | Flag write enable |
| tag_trap_o | output | 1 | Tag overflow trap request |

## Verification
The assertions assume that every input has a known value on every clock edge after reset, and that a flag output is meaningful only while `cc_we_o` is high. The stimulus drives every input from time zero and changes it only away from the sampling edge. Random operands have their tag bits cleared about half the time. This mix keeps tagged operations that do not trap well represented next to those that fault, and lets the random mix reach every modifier combination.

// File: rtl/tag_alu_pkg.sv
package tag_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned TAG_W  = 2;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_EXTEND = 2'b01,
        MODE_TAGGED = 2'b10,
        MODE_TAGTRP = 2'b11
    } mode_e;

    function automatic mode_e pick_mode(input logic ext, input logic tag, input logic trp);
        if (tag && trp)  return MODE_TAGTRP;
        else if (tag)    return MODE_TAGGED;
        else if (ext)    return MODE_EXTEND;
        else             return MODE_PLAIN;
    endfunction

endpackage

// File: rtl/tag_alu_adder.sv
module tag_alu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        c0      = sub_i ? ~cin_i : cin_i;
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum_o   = wide[W-1:0];
        carry_o = sub_i ? ~wide[W] : wide[W];
        ovf_o   = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/tag_alu_tagchk.sv
module tag_alu_tagchk #(
    parameter int unsigned W    = 32,
    parameter int unsigned TAGW = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         bad_o
);
    logic [TAGW-1:0] bits;

    for (genvar g = 0; g < TAGW; g++) begin : g_tag
        assign bits[g] = a_i[g] | b_i[g];
    end

    assign bad_o = |bits;
endmodule

// File: rtl/tag_alu_flags.sv
module tag_alu_flags
    import tag_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] sum_i,
    input  logic         carry_i,
    input  logic         ovf_i,
    input  logic         tag_bad_i,
    input  mode_e        mode_i,
    output cc_t          cc_o,
    output logic         fault_o
);
    logic tag_mode;

    always_comb begin
        tag_mode = (mode_i == MODE_TAGGED) || (mode_i == MODE_TAGTRP);
        cc_o.n   = sum_i[W-1];
        cc_o.z   = (sum_i == '0);
        cc_o.c   = carry_i;
        cc_o.v   = ovf_i | (tag_mode & tag_bad_i);
        fault_o  = (mode_i == MODE_TAGTRP) && (ovf_i || tag_bad_i);
    end
endmodule

// File: rtl/tag_alu.sv
module tag_alu
    import tag_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              sub_i,
    input  logic              extend_i,
    input  logic              tagged_i,
    input  logic              trap_en_i,
    input  logic              set_cc_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] result_o,
    output logic              res_we_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o,
    output logic              flag_c_o,
    output logic              cc_we_o,
    output logic              tag_trap_o
);
    mode_e             mode;
    logic              cin;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
    logic              tag_bad;
    logic              fault;
    cc_t               cc_next;
    cc_t               cc_q;

    always_comb begin
        mode = pick_mode(extend_i, tagged_i, trap_en_i);
        unique case (mode)
            MODE_EXTEND: cin = carry_i;
            default:     cin = 1'b0;
        endcase
    end

    tag_alu_adder #(.W(DATA_W)) u_adder (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (sub_i),
        .cin_i   (cin),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    tag_alu_tagchk #(.W(DATA_W), .TAGW(TAG_W)) u_tagchk (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .bad_o (tag_bad)
    );

    tag_alu_flags #(.W(DATA_W)) u_flags (
        .sum_i     (sum),
        .carry_i   (carry),
        .ovf_i     (ovf),
        .tag_bad_i (tag_bad),
        .mode_i    (mode),
        .cc_o      (cc_next),
        .fault_o   (fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o   <= '0;
            cc_q       <= '0;
            res_we_o   <= 1'b0;
            cc_we_o    <= 1'b0;
            tag_trap_o <= 1'b0;
        end else begin
            res_we_o   <= issue_i & ~fault;
            cc_we_o    <= issue_i & ~fault & set_cc_i;
            tag_trap_o <= issue_i & fault;
            if (issue_i) begin
                result_o <= sum;
                cc_q     <= cc_next;
            end
        end
    end

    always_comb begin
        flag_n_o = cc_q.n;
        flag_z_o = cc_q.z;
        flag_v_o = cc_q.v;
        flag_c_o = cc_q.c;
    end
endmodule

// File: rtl/tag_alu_chk.sv
module tag_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_i,
    input logic        tagged_i,
    input logic        trap_en_i,
    input logic        set_cc_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic [31:0] result_o,
    input logic        res_we_o,
    input logic        flag_n_o,
    input logic        flag_z_o,
    input logic        flag_v_o,
    input logic        cc_we_o,
    input logic        tag_trap_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!res_we_o && !cc_we_o && !tag_trap_o));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we_o |-> (flag_z_o == (result_o == 32'd0)));

    // R5
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we_o |-> (flag_n_o == result_o[31]));

    // R7
    tag_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && tagged_i && !trap_en_i && set_cc_i && ((opa_i[1:0] | opb_i[1:0]) != 2'b00))
        |=> (cc_we_o && flag_v_o));

    // R9
    trap_nocommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_trap_o |-> (!res_we_o && !cc_we_o));

    // R10
    trap_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !tagged_i) |=> !tag_trap_o);

    // R11
    cc_implies_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we_o |-> res_we_o);
endmodule

bind tag_alu tag_alu_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .tagged_i   (tagged_i),
    .trap_en_i  (trap_en_i),
    .set_cc_i   (set_cc_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .result_o   (result_o),
    .res_we_o   (res_we_o),
    .flag_n_o   (flag_n_o),
    .flag_z_o   (flag_z_o),
    .flag_v_o   (flag_v_o),
    .cc_we_o    (cc_we_o),
    .tag_trap_o (tag_trap_o)
);

// File: tb/test_tag_alu.sv
module test_tag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0, sub_i = 1'b0, extend_i = 1'b0, tagged_i = 1'b0;
    logic        trap_en_i = 1'b0, set_cc_i = 1'b0, carry_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [31:0] result_o;
    logic        res_we_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o, cc_we_o, tag_trap_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tag_alu i_tag_alu (.*);

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic s, input logic e, input logic t,
                          input logic tr, input logic cc, input logic ci,
                          input logic [31:0] a, input logic [31:0] b);
        logic        cin, tagbad, ovf, vexp, trap, cexp;
        logic [32:0] u;
        logic [32:0] sv;
        logic [31:0] r;
        @(negedge clk);
        issue_i = 1'b1; sub_i = s; extend_i = e; tagged_i = t; trap_en_i = tr;
        set_cc_i = cc; carry_i = ci; opa_i = a; opb_i = b;
        // R4 R8: carry-in selection
        cin = (e && !t) ? ci : 1'b0;
        if (s) begin
            u  = {1'b0, a} - {1'b0, b} - {32'd0, cin};
            sv = {a[31], a} - {b[31], b} - {32'd0, cin};
        end else begin
            u  = {1'b0, a} + {1'b0, b} + {32'd0, cin};
            sv = {a[31], a} + {b[31], b} + {32'd0, cin};
        end
        r      = u[31:0];
        cexp   = u[32];
        ovf    = (sv[32] != sv[31]);
        tagbad = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
        vexp   = ovf || (t && tagbad);
        trap   = t && tr && vexp;
        @(negedge clk);
        issue_i = 1'b0;
        if (trap) begin
            check(req, "trap R9", {31'd0, tag_trap_o}, 32'd1);
            check(req, "no commit R9", {30'd0, res_we_o, cc_we_o}, 32'd0);
        end else begin
            check(req, "no trap R10", {31'd0, tag_trap_o}, 32'd0);
            check(req, "result R2/R3", result_o, r);
            check(req, "we R11", {30'd0, res_we_o, cc_we_o}, {30'd0, 1'b1, cc});
            if (cc)
                check(req, "flags nzvc R5/R6/R7", {28'd0, flag_n_o, flag_z_o, flag_v_o, flag_c_o},
                      {28'd0, r[31], (r == 32'd0), vexp, cexp});
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0A17);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset strobes", {29'd0, res_we_o, cc_we_o, tag_trap_o}, 32'd0);
        check("R1", "reset result", result_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle strobes", {29'd0, res_we_o, cc_we_o, tag_trap_o}, 32'd0);

        run_op("R2", 0, 0, 0, 0, 1, 1, 32'd5, 32'd7);
        run_op("R2", 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'd1);
        run_op("R4", 0, 1, 0, 0, 1, 1, 32'hFFFF_FFFE, 32'd1);
        run_op("R3", 1, 0, 0, 0, 1, 0, 32'd3, 32'd5);
        run_op("R3", 1, 1, 0, 0, 1, 1, 32'd5, 32'd5);
        run_op("R5", 1, 0, 0, 0, 1, 0, 32'h1234_5678, 32'h1234_5678);
        run_op("R6", 0, 0, 0, 0, 1, 0, 32'h7FFF_FFFF, 32'd1);
        run_op("R6", 1, 0, 0, 0, 1, 0, 32'h8000_0000, 32'd1);
        run_op("R7", 0, 0, 1, 0, 1, 0, 32'd4, 32'd9);
        run_op("R7", 0, 0, 1, 0, 1, 0, 32'd4, 32'd8);
        run_op("R8", 0, 1, 1, 0, 1, 1, 32'd4, 32'd8);
        run_op("R8", 1, 1, 1, 0, 1, 1, 32'd8, 32'd8);
        run_op("R9", 0, 0, 1, 1, 1, 0, 32'd2, 32'd4);
        run_op("R9", 1, 0, 1, 1, 0, 0, 32'h8000_0000, 32'd4);
        run_op("R10", 0, 0, 0, 1, 1, 0, 32'd3, 32'd1);
        run_op("R11", 0, 0, 0, 0, 0, 0, 32'd10, 32'd20);
        run_op("R11", 0, 0, 1, 1, 0, 0, 32'd16, 32'd4);
        @(negedge clk);
        check("R1", "idle after ops", {29'd0, res_we_o, cc_we_o, tag_trap_o}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            logic [5:0]  k;
            a = $urandom; b = $urandom; k = 6'($urandom);
            if ($urandom_range(1, 0) == 1) begin a[1:0] = 2'b00; b[1:0] = 2'b00; end
            if ($urandom_range(7, 0) == 0) b = a;
            run_op("R2 R3 R6 R7", k[0], k[1], k[2], k[3], k[4], k[5], a, b);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule